// File: doc/BRIEF.md
# Synchronous USART Serial Clock Engine

This block is the synchronous-mode front end of a USART. It turns parallel bytes into framed serial bits on a data output pin and gathers serial bits from a data input pin back into bytes. The serial clock that paces both directions comes from one of two places, picked at run time. As clock master, the block makes the serial clock itself from a half-bit tick supplied by a baud generator. As clock slave, it takes an external clock, passes it through a synchronizer and finds its edges in the system clock domain.

A frame is one low start bit, then the data bits least significant first, then one high stop bit. Transmit data changes on falling serial clock edges and is sampled on rising edges. As master, the block normally pulses the clock only during data bits. With the continuous-clock option it keeps the clock toggling through start bits, stop bits and idle time, so an attached slave can send to it even when it has nothing to send. In the continuous case and in slave mode the receiver waits for a start bit. In the gated master case it takes the data-bit pulses of each frame directly as data. Bit counts in the two directions need not match when the clock stops; whole characters are left to the protocol above.

Top module: `usart_sync_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, sclk_out is 1, sdo is 1 (idle level), tx_ready is 1 and rx_valid is 0.
- R2: A transmitted frame on sdo is one 0 start bit, then DATA_BITS data bits least significant first, then one 1 stop bit. In master mode, sdo changes only on the clock cycle after a cycle where half_tick is 1.
- R3: In master mode (mode_master = 1), each half_tick flips an internal bit phase. The phase going high to low is a falling bit edge, and low to high is a rising bit edge. sclk_out changes only on the cycle after a half_tick.
- R4: In gated master mode (cont_clk = 0), sclk_out goes low only for data bits. It gives exactly DATA_BITS low pulses per frame and stays 1 during start bits, stop bits and idle time.
- R5: In continuous master mode (cont_clk = 1), sclk_out follows the bit phase on every half_tick, including when no frame is being sent.
- R6: In master mode, sdi is sampled directly on each rising edge of sclk_out. With cont_clk = 1 the receiver first waits for a sampled 0 start bit. With cont_clk = 0 every sampled bit is data, so the first pulse of each frame gives data bit 0.
- R7: rx_valid is 1 for exactly one cycle, the cycle after the sampling edge of the last data bit. In that cycle rx_data holds the bits received, the first received bit at bit 0.
- R8: In slave mode (mode_master = 0), sclk_in passes through SYNC_STAGES flops before edge detection, and the transmitter advances only on a detected falling edge. sdo reaches its new value by the SYNC_STAGES+1st rising clk edge after sclk_in falls.
- R9: In slave mode, sdi is synchronized with the same depth as sclk_in. It is sampled on a detected rising edge, and the receiver waits for a 0 start bit before taking data.
- R10: tx_ready is 1 only when no byte is waiting and the transmitter is idle or in a stop bit. A byte is taken when tx_valid and tx_ready are both 1, after which tx_ready drops. A byte taken during a stop bit starts its start bit at the next falling edge, with no idle bit in between.
- R11: sclk_oe equals mode_master.
- R12: In slave mode, half_tick has no effect: sclk_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 selects master clocking, 0 selects slave clocking |
| cont_clk | input | 1 | Master only: keep the serial clock running outside data bits |
| half_tick | input | 1 | Half-bit-period strobe from the baud generator |
| tx_data | input | DATA_BITS | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | A byte can be taken this cycle |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new byte |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode), idle 1 |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, idle 1 |

## Verification
A wrong bit phase or gate state shows on sclk_out on the very next half_tick, as a missing, extra or misplaced pulse. A corrupted transmit state or bit index shows on sdo at the next falling bit edge, and a wrong pending flag shows on tx_ready at once. Receive faults only appear at the end of a byte: a lost start bit or a miscounted bit shifts or drops the rx_valid strobe, or gives a rotated rx_data, at the rising edge of the last data bit. In slave mode, an edge detector fault moves sdo by whole bits, which shows at the sample taken at the next external rising edge.

// File: rtl/usart_sync_pkg.sv
package usart_sync_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_START = 2'd1,
      TX_DATA  = 2'd2,
      TX_STOP  = 2'd3
   } tx_state_e;

   typedef enum logic {
      RX_HUNT = 1'b0,
      RX_BITS = 1'b1
   } rx_state_e;

   localparam logic LINE_IDLE  = 1'b1;
   localparam logic START_BIT  = 1'b0;
   localparam logic STOP_BIT   = 1'b1;

endpackage

// File: rtl/usync_master_clk.sv
module usync_master_clk (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic half_tick,
   input  logic cont_clk,
   input  logic tx_next_data,
   output logic sclk_out,
   output logic fall_ev,
   output logic rise_ev
);

   logic phase_q;

   // falling bit edge whenever the phase leaves its high half
   assign fall_ev = enable & half_tick & phase_q;
   // a rising edge only counts when the pin really was low
   assign rise_ev = enable & half_tick & ~phase_q & ~sclk_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= 1'b1;
         sclk_out <= 1'b1;
      end else if (!enable) begin
         phase_q  <= 1'b1;
         sclk_out <= 1'b1;
      end else if (half_tick) begin
         if (phase_q) begin
            phase_q  <= 1'b0;
            sclk_out <= ~(cont_clk | tx_next_data);
         end else begin
            phase_q  <= 1'b1;
            sclk_out <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/usync_slave_edge.sv
module usync_slave_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic sclk_in,
   input  logic sdi,
   output logic fall_ev,
   output logic rise_ev,
   output logic sdi_sync
);

   localparam int LAST = SYNC_STAGES - 1;

   logic [LAST:0] sck_q;
   logic [LAST:0] dat_q;
   logic          sck_prev_q;

   generate
      if (SYNC_STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q <= '1;
               dat_q <= '1;
            end else begin
               sck_q <= {sck_q[0], sclk_in};
               dat_q <= {dat_q[0], sdi};
            end
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q <= '1;
               dat_q <= '1;
            end else begin
               sck_q <= {sck_q[LAST-1:0], sclk_in};
               dat_q <= {dat_q[LAST-1:0], sdi};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev_q <= 1'b1;
      else        sck_prev_q <= sck_q[LAST];
   end

   assign fall_ev  = enable & sck_prev_q & ~sck_q[LAST];
   assign rise_ev  = enable & ~sck_prev_q & sck_q[LAST];
   assign sdi_sync = dat_q[LAST];

endmodule

// File: rtl/usync_tx.sv
module usync_tx
   import usart_sync_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fall_ev,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   output logic                 sdo,
   output logic                 next_data
);

   localparam int IW = $clog2(DATA_BITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

   tx_state_e            state_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] shreg_q;
   logic                 pend_q;
   logic [IW-1:0]        idx_inc;

   assign idx_inc   = idx_q + 1'b1;
   assign tx_ready  = ~pend_q & ((state_q == TX_IDLE) | (state_q == TX_STOP));
   assign next_data = (state_q == TX_START) |
                      ((state_q == TX_DATA) & (idx_q != LAST_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
         shreg_q <= '0;
         pend_q  <= 1'b0;
         sdo     <= LINE_IDLE;
      end else begin
         if (fall_ev) begin
            unique case (state_q)
               TX_IDLE, TX_STOP: begin
                  if (pend_q) begin
                     state_q <= TX_START;
                     pend_q  <= 1'b0;
                     sdo     <= START_BIT;
                  end else begin
                     state_q <= TX_IDLE;
                     sdo     <= LINE_IDLE;
                  end
               end
               TX_START: begin
                  state_q <= TX_DATA;
                  idx_q   <= '0;
                  sdo     <= shreg_q[0];
               end
               TX_DATA: begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= TX_STOP;
                     sdo     <= STOP_BIT;
                  end else begin
                     idx_q <= idx_inc;
                     sdo   <= shreg_q[idx_inc];
                  end
               end
               default: state_q <= TX_IDLE;
            endcase
         end
         if (tx_valid && tx_ready) begin
            shreg_q <= tx_data;
            pend_q  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/usync_rx.sv
module usync_rx
   import usart_sync_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rise_ev,
   input  logic                 sample,
   input  logic                 hunt_en,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid
);

   localparam int IW = $clog2(DATA_BITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

   rx_state_e            state_q;
   logic [IW-1:0]        cnt_q;
   logic [DATA_BITS-1:0] sh_q;
   logic [DATA_BITS-1:0] sh_next;

   assign sh_next = {sample, sh_q[DATA_BITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_HUNT;
         cnt_q    <= '0;
         sh_q     <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise_ev) begin
            if (state_q == RX_HUNT) begin
               if (!hunt_en) begin
                  // gated clock: first pulse already carries data bit 0
                  sh_q    <= sh_next;
                  cnt_q   <= IW'(1);
                  state_q <= RX_BITS;
               end else if (sample == START_BIT) begin
                  cnt_q   <= '0;
                  state_q <= RX_BITS;
               end
            end else begin
               sh_q <= sh_next;
               if (cnt_q == LAST_IDX) begin
                  rx_data  <= sh_next;
                  rx_valid <= 1'b1;
                  state_q  <= RX_HUNT;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/usart_sync_engine.sv
module usart_sync_engine #(
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_master,
   input  logic                 cont_clk,
   input  logic                 half_tick,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   input  logic                 sclk_in,
   output logic                 sclk_out,
   output logic                 sclk_oe,
   input  logic                 sdi,
   output logic                 sdo
);

   generate
      if (DATA_BITS < 2 || DATA_BITS > 32) begin : g_bad_width
         $error("usart_sync_engine: DATA_BITS must lie in 2..32");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("usart_sync_engine: SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   logic m_fall, m_rise;
   logic s_fall, s_rise, s_sdi;
   logic fall_ev, rise_ev, sample, hunt_en, tx_next_data;

   usync_master_clk u_mclk (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (mode_master),
      .half_tick    (half_tick),
      .cont_clk     (cont_clk),
      .tx_next_data (tx_next_data),
      .sclk_out     (sclk_out),
      .fall_ev      (m_fall),
      .rise_ev      (m_rise)
   );

   usync_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sedge (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (~mode_master),
      .sclk_in  (sclk_in),
      .sdi      (sdi),
      .fall_ev  (s_fall),
      .rise_ev  (s_rise),
      .sdi_sync (s_sdi)
   );

   // master captures the raw pin in its own domain; slave uses the synced copy
   assign fall_ev = mode_master ? m_fall : s_fall;
   assign rise_ev = mode_master ? m_rise : s_rise;
   assign sample  = mode_master ? sdi    : s_sdi;
   assign hunt_en = ~(mode_master & ~cont_clk);
   assign sclk_oe = mode_master;

   usync_tx #(.DATA_BITS(DATA_BITS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_ev   (fall_ev),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .sdo       (sdo),
      .next_data (tx_next_data)
   );

   usync_rx #(.DATA_BITS(DATA_BITS)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_ev  (rise_ev),
      .sample   (sample),
      .hunt_en  (hunt_en),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

endmodule

// File: rtl/usart_sync_engine_chk.sv
module usart_sync_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_master,
   input logic half_tick,
   input logic tx_valid,
   input logic tx_ready,
   input logic sclk_out,
   input logic sdo,
   input logic rx_valid,
   input logic slave_fall
);

   // R2: master data line moves only after a baud half tick
   a_r2_sdo_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_master && $past(mode_master) && !$stable(sdo)) |-> $past(half_tick));

   // R3: master clock pin moves only after a baud half tick
   a_r3_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_master && $past(mode_master) && !$stable(sclk_out)) |-> $past(half_tick));

   // R12: slave mode holds the generated clock high
   a_r12_slave_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_master |=> sclk_out);

   // R7: received-byte strobe lasts one cycle
   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R10: taking a byte closes the handshake
   a_r10_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   // R8: in slave mode the data line moves only after a detected falling edge
   a_r8_slave_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_master && !$past(mode_master) && !$stable(sdo)) |-> $past(slave_fall));

endmodule

bind usart_sync_engine usart_sync_engine_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_master (mode_master),
   .half_tick   (half_tick),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .sclk_out    (sclk_out),
   .sdo         (sdo),
   .rx_valid    (rx_valid),
   .slave_fall  (s_fall)
);

// File: tb/usart_sync_engine_test.sv
module usart_sync_engine_test;

   localparam int DW = 8;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_master = 1'b1;
   logic cont_clk = 1'b0;
   logic half_tick = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic sclk_in = 1'b1;
   logic sdi_drv = 1'b1;
   logic loop = 1'b1;
   logic tx_ready, rx_valid, sclk_out, sclk_oe, sdo, sdi;
   logic [DW-1:0] rx_data;

   assign sdi = loop ? sdo : sdi_drv;

   usart_sync_engine #(.DATA_BITS(DW), .SYNC_STAGES(NS)) uut (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .cont_clk(cont_clk),
      .half_tick(half_tick), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
      .sdi(sdi), .sdo(sdo));

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // half tick source
   int div = 0;
   int tcnt = 0;
   always @(negedge clk) begin
      if (div > 0) begin
         tcnt = tcnt + 1;
         if (tcnt >= div) begin tcnt = 0; half_tick = 1'b1; end
         else half_tick = 1'b0;
      end else half_tick = 1'b0;
   end

   // behavioural master model: pos -1 idle, 0 start, 1..DW data, DW+1 stop
   bit model_on = 0;
   int m_pos, m_rcnt;
   bit m_pend, m_ph, m_sclk, m_sdo, m_rv;
   logic [DW-1:0] m_hold, m_cur, m_rsh, m_rdata;
   bit f_ev, r_ev, acc, smp, nrv;

   function automatic bit m_ready();
      return !m_pend && (m_pos == -1 || m_pos == DW + 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = -1; m_rcnt = -1; m_pend = 0; m_ph = 1; m_sclk = 1; m_sdo = 1; m_rv = 0;
         m_hold = '0; m_cur = '0; m_rsh = '0; m_rdata = '0;
      end else if (mode_master) begin
         f_ev = half_tick && m_ph;
         r_ev = half_tick && !m_ph;
         acc  = tx_valid && m_ready();
         nrv  = 0;
         if (f_ev) begin
            if (m_pos == -1 || m_pos == DW + 1) begin
               if (m_pend) begin m_pos = 0; m_pend = 0; m_cur = m_hold; end
               else m_pos = -1;
            end else m_pos = m_pos + 1;
            if (m_pos == 0) m_sdo = 0;
            else if (m_pos >= 1 && m_pos <= DW) m_sdo = m_cur[m_pos-1];
            else m_sdo = 1;
            m_ph = 0;
            m_sclk = (cont_clk || (m_pos >= 1 && m_pos <= DW)) ? 1'b0 : 1'b1;
         end else if (r_ev) begin
            if (!m_sclk) begin
               smp = loop ? m_sdo : sdi_drv;
               if (m_rcnt < 0) begin
                  if (!cont_clk) begin m_rsh = {smp, m_rsh[DW-1:1]}; m_rcnt = 1; end
                  else if (!smp) m_rcnt = 0;
               end else begin
                  m_rsh = {smp, m_rsh[DW-1:1]};
                  m_rcnt = m_rcnt + 1;
                  if (m_rcnt == DW) begin nrv = 1; m_rdata = m_rsh; m_rcnt = -1; end
               end
            end
            m_ph = 1; m_sclk = 1;
         end
         if (acc) begin m_hold = tx_data; m_pend = 1; end
         m_rv = nrv;
      end
   end

   // per-clock comparison against the model (master phases)
   always @(negedge clk) begin
      if (model_on && rst_n) begin
         chk(sclk_out === m_sclk, "R3 sclk_out", sclk_out, m_sclk);
         chk(sdo === m_sdo, "R2 sdo", sdo, m_sdo);
         chk(tx_ready === m_ready(), "R10 tx_ready", tx_ready, m_ready());
         chk(rx_valid === m_rv, "R7 rx_valid", rx_valid, m_rv);
         if (m_rv) chk(rx_data === m_rdata, "R7 rx_data", rx_data, m_rdata);
         chk(sclk_oe === 1'b1, "R11 sclk_oe", sclk_oe, 1);
      end
   end

   // slave phase: generated clock idle, pin not driven
   bit slave_on = 0;
   always @(negedge clk) begin
      if (slave_on && rst_n) begin
         chk(sclk_out === 1'b1, "R12 sclk_out", sclk_out, 1);
         chk(sclk_oe === 1'b0, "R11 sclk_oe", sclk_oe, 0);
      end
   end

   // monitors
   logic [DW-1:0] rxq[$];
   int falls = 0;
   logic prev_sclk = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) rxq.push_back(rx_data);
         if (prev_sclk && !sclk_out) falls++;
      end
      prev_sclk = sclk_out;
   end

   task automatic do_reset(input bit mm, input bit cc, input int d, input bit lp);
      @(negedge clk);
      rst_n = 0; model_on = 0; slave_on = 0;
      mode_master = mm; cont_clk = cc; div = d; tcnt = 0; loop = lp;
      repeat (3) @(negedge clk);
      rst_n = 1;
      rxq.delete(); falls = 0;
      model_on = mm; slave_on = !mm;
   endtask

   task automatic send(input logic [DW-1:0] b);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data = b; tx_valid = 1;
      @(negedge clk);
      tx_valid = 0;
   endtask

   task automatic slave_frame(input logic [DW-1:0] tb, input logic [DW-1:0] rb);
      logic [DW+2:0] rf, ef;
      rf = {2'b11, rb, 1'b0};
      ef = {2'b11, tb, 1'b0};
      rxq.delete();
      send(tb);
      chk(tx_ready === 1'b0, "R10 ready low after accept", tx_ready, 0);
      for (int k = 0; k < DW + 3; k++) begin
         @(negedge clk);
         sclk_in = 0; sdi_drv = rf[k];
         repeat (NS + 2) @(negedge clk);
         chk(sdo === ef[k], "R8 slave sdo after fall", sdo, ef[k]);
         repeat (8 - (NS + 2)) @(negedge clk);
         sclk_in = 1;
         repeat (8) @(negedge clk);
      end
      chk(rxq.size() == 1, "R9 slave rx count", rxq.size(), 1);
      if (rxq.size() > 0) chk(rxq[0] === rb, "R9 slave rx byte", rxq[0], rb);
   endtask

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      chk(sclk_out === 1'b1, "R1 sclk_out", sclk_out, 1);
      chk(sdo === 1'b1, "R1 sdo", sdo, 1);
      chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
      chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);

      // gated master, fast ticks, loopback, back-to-back bytes
      do_reset(1, 0, 1, 1);
      chk(sclk_out === 1'b1 && sdo === 1'b1, "R1 after release", {sclk_out, sdo}, 3);
      send(8'hA5);
      send(8'h3C);
      repeat (80) @(negedge clk);
      chk(falls == 2 * DW, "R4 gated pulse count", falls, 2 * DW);
      chk(rxq.size() == 2, "R6 gated rx count", rxq.size(), 2);
      if (rxq.size() == 2) begin
         chk(rxq[0] === 8'hA5, "R6 gated byte 0", rxq[0], 8'hA5);
         chk(rxq[1] === 8'h3C, "R6 gated byte 1", rxq[1], 8'h3C);
      end

      // continuous master, slower ticks
      do_reset(1, 1, 3, 1);
      repeat (60) @(negedge clk);
      chk(falls >= 9, "R5 idle clock runs", falls, 9);
      send(8'h81);
      send(8'h7E);
      repeat (200) @(negedge clk);
      chk(rxq.size() == 2, "R6 hunt rx count", rxq.size(), 2);
      if (rxq.size() == 2) begin
         chk(rxq[0] === 8'h81, "R6 hunt byte 0", rxq[0], 8'h81);
         chk(rxq[1] === 8'h7E, "R6 hunt byte 1", rxq[1], 8'h7E);
      end

      // external line held high: continuous mode never sees a start bit
      do_reset(1, 1, 2, 0);
      sdi_drv = 1;
      send(8'h12);
      repeat (120) @(negedge clk);
      chk(rxq.size() == 0, "R6 no start no byte", rxq.size(), 0);

      // gated mode with line high takes the pulses as data
      do_reset(1, 0, 2, 0);
      sdi_drv = 1;
      send(8'h00);
      repeat (120) @(negedge clk);
      chk(rxq.size() == 1, "R6 gated raw count", rxq.size(), 1);
      if (rxq.size() == 1) chk(rxq[0] === 8'hFF, "R6 gated raw byte", rxq[0], 8'hFF);

      // slave mode with half ticks still running
      do_reset(0, 0, 2, 0);
      sclk_in = 1; sdi_drv = 1;
      repeat (20) @(negedge clk);
      chk(sdo === 1'b1, "R8 slave idle sdo", sdo, 1);
      slave_frame(8'h5A, 8'hC3);
      slave_frame(8'h01, 8'h80);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1..all actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule